// File: doc/BRIEF.md
# Direction-Latched Dual Buffer Router

This block sits between a data-transfer engine and two byte buffers of unequal size, one large (2048 entries by default) and one small (48 entries by default). It gives each buffer a role for the length of one transfer. In transmit direction the large buffer carries outgoing data and the small one stands unused. In receive direction the small buffer carries the outgoing stream, and the large one collects incoming data.

The direction bit is sampled only when an idle engine is started. The role assignment then stays frozen until the engine signals that it is finished. Between transfers every handshake toward the buffers is closed. A buffer's contents survive a restart in the same direction. They are cleared when a new transfer latches the opposite direction. Ordinary request and response packets use a separate pair of FIFOs and never pass through this block.

Top module: `dual_buf_router`

## Requirements
- R1: While busy, changes on `dir_i` have no effect on `dir_q_o` or on how the paths are routed.
- R2: A `start_i` pulse while idle sets `busy_o` at the next clock edge and latches `dir_i` into `dir_q_o`. Value 0 means transmit and value 1 means receive.
- R3: In transmit direction the transmit path is served in first-in first-out order by the large buffer. It accepts exactly BIG_DEPTH entries before `tx_full_o` rises and `tx_wr_ready_o` falls.
- R4: In transmit direction the receive path is dead. `rx_wr_ready_o` and `rx_rd_valid_o` are 0, `rx_empty_o` is 1 and `rx_full_o` is 0, and receive writes are ignored.
- R5: In receive direction the small buffer serves the transmit path and becomes full after exactly SMALL_DEPTH entries. The large buffer serves the receive path in first-in first-out order.
- R6: A `finish_i` pulse while busy clears `busy_o` at the next edge. A `finish_i` pulse while idle has no effect.
- R7: While idle, all ready and valid outputs are 0, both empty flags read 1 and both full flags read 0. Writes and reads are ignored, and buffer contents are kept.
- R8: A `start_i` pulse while busy is ignored. It causes no re-latch and no flush. When `start_i` and `finish_i` arrive together while busy, the finish takes effect.
- R9: An accepted start whose direction differs from the previously latched one empties both buffers. The previously latched direction after reset is transmit. A start in the same direction keeps their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_i | input | 1 | Requested direction (0 transmit, 1 receive) |
| start_i | input | 1 | Engine start strobe |
| finish_i | input | 1 | Engine completion strobe |
| busy_o | output | 1 | Transfer in progress, roles frozen |
| dir_q_o | output | 1 | Latched direction |
| tx_wr_valid_i | input | 1 | Outgoing data offered to the transmit buffer |
| tx_wr_data_i | input | DATA_W | Outgoing data byte |
| tx_wr_ready_o | output | 1 | Transmit buffer accepts a byte |
| tx_rd_valid_o | output | 1 | Transmit buffer holds a byte for the engine |
| tx_rd_data_o | output | DATA_W | Head of the transmit buffer |
| tx_rd_ready_i | input | 1 | Engine takes the head byte |
| rx_wr_valid_i | input | 1 | Engine offers an incoming byte |
| rx_wr_data_i | input | DATA_W | Incoming data byte |
| rx_wr_ready_o | output | 1 | Receive buffer accepts a byte |
| rx_rd_valid_o | output | 1 | Receive buffer holds a byte |
| rx_rd_data_o | output | DATA_W | Head of the receive buffer |
| rx_rd_ready_i | input | 1 | Consumer takes the head byte |
| tx_full_o | output | 1 | Buffer in transmit role is full |
| tx_empty_o | output | 1 | Buffer in transmit role is empty |
| rx_full_o | output | 1 | Buffer in receive role is full |
| rx_empty_o | output | 1 | Buffer in receive role is empty |

## Verification
The properties assume that `start_i` and `finish_i` are single-cycle strobes. They also assume that nothing is read or written through a path whose ready or valid output is low, since such handshakes are simply dropped. The stimulus drives every strobe for exactly one cycle, changing it on the falling clock edge. It also changes `dir_i` while busy, pulses start during a transfer, pulses both strobes together, and offers receive data in transmit direction. Those cases are meant to be absorbed by the block, and the properties state what absorbing them must look like.

// File: rtl/drb_pkg.sv
// Package: shared types for the dual buffer router.
// Assumes: one direction bit, 0 = transmit, 1 = receive.
package drb_pkg;
    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } xfer_dir_e;
endpackage

// File: rtl/drb_fifo.sv
// Module: drb_fifo
// What: first-word-fall-through FIFO of DEPTH entries with a synchronous flush.
// Assumes: DEPTH need not be a power of two. Writes to a full FIFO and reads
// from an empty one are dropped. Flush has priority over both.
module drb_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              full_o,
    output logic              empty_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              do_wr, do_rd;

    assign full_o    = (count == FULL_CNT);
    assign empty_o   = (count == '0);
    assign do_wr     = wr_en_i && !full_o;
    assign do_rd     = rd_en_i && !empty_o;
    assign rd_data_o = mem[rd_ptr];

    // Store an accepted byte at the write pointer.
    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wr_ptr] <= wr_data_i;
        end
    end

    // Advance pointers and occupancy; reset and flush clear them.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
            end
            if (do_rd) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
            end
            if (do_wr && !do_rd) begin
                count <= count + CNT_W'(1);
            end else if (do_rd && !do_wr) begin
                count <= count - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/drb_role_ctrl.sv
// Module: drb_role_ctrl
// What: holds the busy state and the direction latched at start. It issues a
// flush pulse when an accepted start picks the opposite direction.
// Assumes: start and finish are single-cycle strobes. A start while busy is
// dropped, and a finish wins over a simultaneous start.
module drb_role_ctrl
    import drb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      dir_i,
    input  logic      start_i,
    input  logic      finish_i,
    output logic      busy_o,
    output xfer_dir_e dir_q_o,
    output logic      flush_o
);
    logic      busy_q;
    xfer_dir_e dir_q;
    xfer_dir_e dir_req;
    logic      accept;

    assign dir_req = xfer_dir_e'(dir_i);
    assign accept  = start_i && !busy_q;
    assign flush_o = accept && (dir_req != dir_q);
    assign busy_o  = busy_q;
    assign dir_q_o = dir_q;

    // Busy flag: set by an accepted start, cleared by finish while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else if (busy_q && finish_i) begin
            busy_q <= 1'b0;
        end else if (accept) begin
            busy_q <= 1'b1;
        end
    end

    // Direction register: loaded only on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= DIR_TX;
        end else if (accept) begin
            dir_q <= dir_req;
        end
    end
endmodule

// File: rtl/drb_port_mux.sv
// Module: drb_port_mux
// What: connects the engine's transmit and receive paths to the large and
// small buffers according to the latched direction, and routes their flags.
// Assumes: purely combinational. While idle every path is closed and the
// flags read empty.
module drb_port_mux
    import drb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              busy_i,
    input  xfer_dir_e         dir_i,
    input  logic              tx_wr_valid_i,
    input  logic [DATA_W-1:0] tx_wr_data_i,
    output logic              tx_wr_ready_o,
    output logic              tx_rd_valid_o,
    output logic [DATA_W-1:0] tx_rd_data_o,
    input  logic              tx_rd_ready_i,
    input  logic              rx_wr_valid_i,
    input  logic [DATA_W-1:0] rx_wr_data_i,
    output logic              rx_wr_ready_o,
    output logic              rx_rd_valid_o,
    output logic [DATA_W-1:0] rx_rd_data_o,
    input  logic              rx_rd_ready_i,
    output logic              tx_full_o,
    output logic              tx_empty_o,
    output logic              rx_full_o,
    output logic              rx_empty_o,
    output logic              big_wr_en_o,
    output logic [DATA_W-1:0] big_wr_data_o,
    output logic              big_rd_en_o,
    input  logic [DATA_W-1:0] big_rd_data_i,
    input  logic              big_full_i,
    input  logic              big_empty_i,
    output logic              sml_wr_en_o,
    output logic [DATA_W-1:0] sml_wr_data_o,
    output logic              sml_rd_en_o,
    input  logic [DATA_W-1:0] sml_rd_data_i,
    input  logic              sml_full_i,
    input  logic              sml_empty_i
);
    // Role routing: closed when idle, large=tx in transmit, small=tx/large=rx in receive.
    always_comb begin
        tx_wr_ready_o = 1'b0;
        tx_rd_valid_o = 1'b0;
        tx_rd_data_o  = '0;
        rx_wr_ready_o = 1'b0;
        rx_rd_valid_o = 1'b0;
        rx_rd_data_o  = '0;
        tx_full_o     = 1'b0;
        tx_empty_o    = 1'b1;
        rx_full_o     = 1'b0;
        rx_empty_o    = 1'b1;
        big_wr_en_o   = 1'b0;
        big_wr_data_o = '0;
        big_rd_en_o   = 1'b0;
        sml_wr_en_o   = 1'b0;
        sml_wr_data_o = '0;
        sml_rd_en_o   = 1'b0;
        if (busy_i) begin
            if (dir_i == DIR_TX) begin
                big_wr_en_o   = tx_wr_valid_i;
                big_wr_data_o = tx_wr_data_i;
                big_rd_en_o   = tx_rd_ready_i;
                tx_wr_ready_o = !big_full_i;
                tx_rd_valid_o = !big_empty_i;
                tx_rd_data_o  = big_rd_data_i;
                tx_full_o     = big_full_i;
                tx_empty_o    = big_empty_i;
            end else begin
                sml_wr_en_o   = tx_wr_valid_i;
                sml_wr_data_o = tx_wr_data_i;
                sml_rd_en_o   = tx_rd_ready_i;
                tx_wr_ready_o = !sml_full_i;
                tx_rd_valid_o = !sml_empty_i;
                tx_rd_data_o  = sml_rd_data_i;
                tx_full_o     = sml_full_i;
                tx_empty_o    = sml_empty_i;
                big_wr_en_o   = rx_wr_valid_i;
                big_wr_data_o = rx_wr_data_i;
                big_rd_en_o   = rx_rd_ready_i;
                rx_wr_ready_o = !big_full_i;
                rx_rd_valid_o = !big_empty_i;
                rx_rd_data_o  = big_rd_data_i;
                rx_full_o     = big_full_i;
                rx_empty_o    = big_empty_i;
            end
        end
    end
endmodule

// File: rtl/dual_buf_router.sv
// Module: dual_buf_router
// What: top level. A role controller, a path multiplexer and two FIFOs
// (large and small). The buffer roles follow the direction latched at start.
// Assumes: synchronous active-low reset, single-cycle start/finish strobes.
module dual_buf_router
    import drb_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int BIG_DEPTH = 2048,
    parameter int SML_DEPTH = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_i,
    input  logic              start_i,
    input  logic              finish_i,
    output logic              busy_o,
    output logic              dir_q_o,
    input  logic              tx_wr_valid_i,
    input  logic [DATA_W-1:0] tx_wr_data_i,
    output logic              tx_wr_ready_o,
    output logic              tx_rd_valid_o,
    output logic [DATA_W-1:0] tx_rd_data_o,
    input  logic              tx_rd_ready_i,
    input  logic              rx_wr_valid_i,
    input  logic [DATA_W-1:0] rx_wr_data_i,
    output logic              rx_wr_ready_o,
    output logic              rx_rd_valid_o,
    output logic [DATA_W-1:0] rx_rd_data_o,
    input  logic              rx_rd_ready_i,
    output logic              tx_full_o,
    output logic              tx_empty_o,
    output logic              rx_full_o,
    output logic              rx_empty_o
);
    xfer_dir_e         dir_q;
    logic              flush;
    logic              big_wr_en, big_rd_en, big_full, big_empty;
    logic              sml_wr_en, sml_rd_en, sml_full, sml_empty;
    logic [DATA_W-1:0] big_wr_data, big_rd_data, sml_wr_data, sml_rd_data;

    assign dir_q_o = dir_q;

    drb_role_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .dir_i    (dir_i),
        .start_i  (start_i),
        .finish_i (finish_i),
        .busy_o   (busy_o),
        .dir_q_o  (dir_q),
        .flush_o  (flush)
    );

    drb_port_mux #(.DATA_W(DATA_W)) u_mux (
        .busy_i        (busy_o),
        .dir_i         (dir_q),
        .tx_wr_valid_i (tx_wr_valid_i),
        .tx_wr_data_i  (tx_wr_data_i),
        .tx_wr_ready_o (tx_wr_ready_o),
        .tx_rd_valid_o (tx_rd_valid_o),
        .tx_rd_data_o  (tx_rd_data_o),
        .tx_rd_ready_i (tx_rd_ready_i),
        .rx_wr_valid_i (rx_wr_valid_i),
        .rx_wr_data_i  (rx_wr_data_i),
        .rx_wr_ready_o (rx_wr_ready_o),
        .rx_rd_valid_o (rx_rd_valid_o),
        .rx_rd_data_o  (rx_rd_data_o),
        .rx_rd_ready_i (rx_rd_ready_i),
        .tx_full_o     (tx_full_o),
        .tx_empty_o    (tx_empty_o),
        .rx_full_o     (rx_full_o),
        .rx_empty_o    (rx_empty_o),
        .big_wr_en_o   (big_wr_en),
        .big_wr_data_o (big_wr_data),
        .big_rd_en_o   (big_rd_en),
        .big_rd_data_i (big_rd_data),
        .big_full_i    (big_full),
        .big_empty_i   (big_empty),
        .sml_wr_en_o   (sml_wr_en),
        .sml_wr_data_o (sml_wr_data),
        .sml_rd_en_o   (sml_rd_en),
        .sml_rd_data_i (sml_rd_data),
        .sml_full_i    (sml_full),
        .sml_empty_i   (sml_empty)
    );

    drb_fifo #(.DATA_W(DATA_W), .DEPTH(BIG_DEPTH)) u_big (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (flush),
        .wr_en_i   (big_wr_en),
        .wr_data_i (big_wr_data),
        .rd_en_i   (big_rd_en),
        .rd_data_o (big_rd_data),
        .full_o    (big_full),
        .empty_o   (big_empty)
    );

    drb_fifo #(.DATA_W(DATA_W), .DEPTH(SML_DEPTH)) u_sml (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (flush),
        .wr_en_i   (sml_wr_en),
        .wr_data_i (sml_wr_data),
        .rd_en_i   (sml_rd_en),
        .rd_data_o (sml_rd_data),
        .full_o    (sml_full),
        .empty_o   (sml_empty)
    );
endmodule

// File: rtl/drb_checker.sv
// Module: drb_checker
// What: protocol properties of dual_buf_router, observed at its ports.
// Assumes: bound to every instance of dual_buf_router.
module drb_checker (
    input logic clk,
    input logic rst_n,
    input logic dir_i,
    input logic start_i,
    input logic finish_i,
    input logic busy_o,
    input logic dir_q_o,
    input logic tx_wr_ready_o,
    input logic tx_rd_valid_o,
    input logic rx_wr_ready_o,
    input logic rx_rd_valid_o,
    input logic tx_full_o,
    input logic tx_empty_o,
    input logic rx_full_o,
    input logic rx_empty_o
);
    a_r2_start_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && (dir_q_o == $past(dir_i))));

    a_r1_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(dir_q_o));

    a_r6_finish_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && finish_i) |=> !busy_o);

    a_r8_busy_start_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !finish_i) |=> (busy_o && $stable(dir_q_o)));

    a_r7_idle_closed: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!tx_wr_ready_o && !tx_rd_valid_o && !rx_wr_ready_o
                     && !rx_rd_valid_o && tx_empty_o && rx_empty_o
                     && !tx_full_o && !rx_full_o));

    a_r4_rx_dead_in_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !dir_q_o) |-> (!rx_wr_ready_o && !rx_rd_valid_o
                                  && rx_empty_o && !rx_full_o));

    a_r9_flush_on_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && (dir_i != dir_q_o)) |=> (tx_empty_o && rx_empty_o));

    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_full_o && tx_empty_o) && !(rx_full_o && rx_empty_o));
endmodule

bind dual_buf_router drb_checker u_chk (.*);

// File: tb/dual_buf_router_bench.sv
// Bench: scoreboard for dual_buf_router. The drivers queue the bytes that the
// design accepts, and the monitors pop the queues on each output handshake.
module dual_buf_router_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BIG = 2048;
    localparam int SML = 48;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dir_i = 1'b0, start_i = 1'b0, finish_i = 1'b0;
    logic       busy_o, dir_q_o;
    logic       tx_wr_valid_i = 1'b0, tx_rd_ready_i = 1'b0;
    logic       rx_wr_valid_i = 1'b0, rx_rd_ready_i = 1'b0;
    logic [7:0] tx_wr_data_i = '0, rx_wr_data_i = '0;
    logic [7:0] tx_rd_data_o, rx_rd_data_o;
    logic       tx_wr_ready_o, tx_rd_valid_o, rx_wr_ready_o, rx_rd_valid_o;
    logic       tx_full_o, tx_empty_o, rx_full_o, rx_empty_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_buf_router #(.DATA_W(8), .BIG_DEPTH(BIG), .SML_DEPTH(SML)) u_dual_buf_router (.*);

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
        #2;
    endtask

    task automatic pulse(input logic s, input logic f, input logic d);
        @(negedge clk);
        dir_i = d; start_i = s; finish_i = f;
        @(negedge clk);
        start_i = 1'b0; finish_i = 1'b0;
        #2;
    endtask

    task automatic push_tx(input logic [7:0] b, output bit acc);
        @(negedge clk);
        tx_wr_valid_i = 1'b1; tx_wr_data_i = b;
        #2;
        acc = tx_wr_ready_o;
        if (acc) tx_q.push_back(b);
        @(negedge clk);
        tx_wr_valid_i = 1'b0;
    endtask

    task automatic push_rx(input logic [7:0] b, output bit acc);
        @(negedge clk);
        rx_wr_valid_i = 1'b1; rx_wr_data_i = b;
        #2;
        acc = rx_wr_ready_o;
        if (acc) rx_q.push_back(b);
        @(negedge clk);
        rx_wr_valid_i = 1'b0;
    endtask

    task automatic drain_tx(input int n);
        @(negedge clk);
        tx_rd_ready_i = 1'b1;
        repeat (n) @(negedge clk);
        tx_rd_ready_i = 1'b0;
    endtask

    task automatic drain_rx(input int n);
        @(negedge clk);
        rx_rd_ready_i = 1'b1;
        repeat (n) @(negedge clk);
        rx_rd_ready_i = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Transmit monitor: compare each byte the engine takes (R3, R5 ordering).
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (tx_rd_valid_o && tx_rd_ready_i) begin
                if (tx_q.size() == 0) check("R3 tx byte with empty scoreboard", tx_rd_data_o, -1);
                else check("R3 tx data order", tx_rd_data_o, tx_q.pop_front());
            end
        end
    end

    // Receive monitor: compare each byte the consumer takes (R5 receive role).
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rx_rd_valid_o && rx_rd_ready_i) begin
                if (rx_q.size() == 0) check("R5 rx byte with empty scoreboard", rx_rd_data_o, -1);
                else check("R5 rx data order", rx_rd_data_o, rx_q.pop_front());
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
    end

    initial begin
        bit acc;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R7 reset/idle state
        check("R7 reset busy", busy_o, 0);
        check("R7 reset tx_wr_ready", tx_wr_ready_o, 0);
        check("R7 reset tx_empty", tx_empty_o, 1);
        check("R7 reset rx_empty", rx_empty_o, 1);

        // R2 start transmit
        pulse(1'b1, 1'b0, 1'b0);
        check("R2 busy after start", busy_o, 1);
        check("R2 latched dir", dir_q_o, 0);
        for (int i = 0; i < 10; i++) push_tx(8'(i + 8'h30), acc);
        // R1 direction change mid-transfer
        @(negedge clk); dir_i = 1'b1;
        settle();
        check("R1 dir_q held", dir_q_o, 0);
        check("R1 routing held tx_wr_ready", tx_wr_ready_o, 1);
        // R4 receive path dead in transmit
        push_rx(8'hAA, acc);
        check("R4 rx write refused", acc, 0);
        settle();
        check("R4 rx_empty", rx_empty_o, 1);
        check("R4 rx_rd_valid", rx_rd_valid_o, 0);
        check("R4 rx_full", rx_full_o, 0);
        drain_tx(10);
        settle();
        check("R3 scoreboard drained", tx_q.size(), 0);

        // R3 capacity of the large buffer
        n = 0;
        for (int i = 0; i < BIG; i++) begin
            push_tx(8'(i * 7 + 1), acc);
            if (acc) n++;
        end
        check("R3 accepted count", n, BIG);
        settle();
        check("R3 tx_full", tx_full_o, 1);
        push_tx(8'hEE, acc);
        check("R3 write beyond full refused", acc, 0);
        drain_tx(BIG - 3);
        settle();
        check("R3 leftover count", tx_q.size(), 3);

        // R8 start while busy ignored
        pulse(1'b1, 1'b0, 1'b1);
        check("R8 dir_q unchanged", dir_q_o, 0);
        check("R8 no flush", tx_empty_o, 0);
        check("R8 still busy", busy_o, 1);

        // R6 finish, R7 idle behaviour
        pulse(1'b0, 1'b1, 1'b0);
        check("R6 idle after finish", busy_o, 0);
        check("R7 idle tx_rd_valid", tx_rd_valid_o, 0);
        check("R7 idle tx_empty", tx_empty_o, 1);
        push_tx(8'h55, acc);
        check("R7 idle write refused", acc, 0);
        pulse(1'b0, 1'b1, 1'b0);
        check("R6 finish while idle", busy_o, 0);

        // R9 same direction keeps contents
        pulse(1'b1, 1'b0, 1'b0);
        check("R9 contents kept", tx_empty_o, 0);
        drain_tx(3);
        settle();
        check("R9 kept bytes drained", tx_q.size(), 0);
        for (int i = 0; i < 4; i++) push_tx(8'(i + 8'hC0), acc);
        pulse(1'b0, 1'b1, 1'b0);

        // R9 opposite direction flushes
        pulse(1'b1, 1'b0, 1'b1);
        tx_q.delete();
        check("R2 latched receive", dir_q_o, 1);
        check("R9 tx flushed", tx_empty_o, 1);
        check("R9 rx flushed", rx_empty_o, 1);

        // R5 small buffer as transmit
        n = 0;
        for (int i = 0; i < SML; i++) begin
            push_tx(8'(i + 8'h80), acc);
            if (acc) n++;
        end
        check("R5 small accepted count", n, SML);
        settle();
        check("R5 small tx_full", tx_full_o, 1);
        push_tx(8'h11, acc);
        check("R5 write beyond small refused", acc, 0);
        drain_tx(SML);
        // R5 large buffer as receive
        n = 0;
        for (int i = 0; i < 100; i++) begin
            push_rx(8'(i * 3), acc);
            if (acc) n++;
        end
        check("R5 rx accepted count", n, 100);
        drain_rx(100);
        settle();
        check("R5 rx drained", rx_q.size(), 0);
        check("R5 rx_empty", rx_empty_o, 1);
        check("R5 tx drained", tx_q.size(), 0);

        // R8 finish wins over simultaneous start
        pulse(1'b1, 1'b1, 1'b0);
        check("R8 finish wins", busy_o, 0);
        summary();
    end
endmodule